// File: doc/BRIEF.md
# Fragment Batch Instruction Scheduler

This block paces one shader stage, either the multi-function stage or the arithmetic stage, through the instructions that belong to one fragment-pipeline batch. For each batch the upstream sequencer presents an 8-bit schedule word. The word carries a start offset into the stage's instruction store and a count of zero to three instructions. The scheduler then issues consecutive store indices, one per clock, each with a valid strobe. It marks the final index with a done pulse. A count of zero still occupies exactly one clock. In that clock the block shows a NOP marker and the done pulse, and issues no index.

Each stage instantiates its own copy of the block, so the two stages follow independent schedules. The upstream side uses a start/ready handshake. Ready is high while the block is idle, and also in the final cycle of a batch. A new word can therefore be accepted in that final cycle, and batches run back to back with no gap. Indices that run past the top of the address space wrap to zero.

Top module: `frag_batch_sched`

## Requirements
- R1: After reset and while idle, ready_o is 1 and idx_vld_o, nop_o and done_o are 0.
- R2: Bits 7..2 of sched_i hold the start offset and bits 1..0 hold the instruction count. The word is accepted at a rising clock edge where start_i and ready_o are both 1.
- R3: For a nonzero count, the cycle after the accepting edge shows idx_vld_o = 1 and idx_o equal to the start offset.
- R4: A count N of 1, 2 or 3 gives exactly N consecutive valid cycles, with indices offset, offset+1, and so on.
- R5: done_o is 1 exactly in the cycle that carries the last index of a batch.
- R6: A count of 0 gives exactly one cycle, right after the accepting edge, with nop_o = 1, done_o = 1 and idx_vld_o = 0.
- R7: ready_o is 0 in every batch cycle except the final one. A start_i asserted while ready_o is 0 has no effect on the issued stream.
- R8: A word accepted in the final cycle of a batch starts its first cycle on the very next clock, leaving no idle cycle between the batches.
- R9: With the default configuration, idx_o reads 0 whenever idx_vld_o is 0.
- R10: Indices are taken modulo 64, so offset 63 with count 2 issues 63 and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to accept sched_i |
| sched_i | input | 8 | Schedule word: offset in bits 7..2, count in bits 1..0 |
| ready_o | output | 1 | Block can accept a word at the next edge |
| idx_o | output | 6 | Instruction store index |
| idx_vld_o | output | 1 | idx_o carries an index to execute |
| nop_o | output | 1 | Idle batch cycle for a zero count |
| done_o | output | 1 | Last cycle of the current batch |

## Verification
Every output comes from a register, so the first index or the NOP cycle appears in the clock right after the accepting edge. The k-th index of a batch appears k clocks after that. The bench changes inputs and samples outputs only on the falling edge. Each check therefore covers exactly one batch cycle, counted from the accepting edge. The sweep covers all 256 schedule words. During every non-final batch cycle, the bench drives a conflicting word with start high to show that it is ignored. It then checks one idle cycle after each batch, and runs a held-start chain to confirm that consecutive batches leave no gap.

// File: rtl/frag_sched_pkg.sv
package frag_sched_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;

endpackage

// File: rtl/frag_sched_decode.sv
module frag_sched_decode #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 2,
   localparam int SCHED_W = ADDR_W + CNT_W
) (
   input  logic [SCHED_W-1:0] word_i,
   output logic [ADDR_W-1:0]  base_o,
   output logic [CNT_W-1:0]   span_m1_o,
   output logic               is_nop_o
);

   logic [CNT_W-1:0] count;

   assign base_o   = word_i[SCHED_W-1:CNT_W];
   assign count    = word_i[CNT_W-1:0];
   assign is_nop_o = (count == '0);

   // a zero count still owns one cycle, so its span is one (stored as 0)
   assign span_m1_o = is_nop_o ? '0 : CNT_W'(count - CNT_W'(1));

endmodule

// File: rtl/frag_sched_track.sv
module frag_sched_track #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              advance_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  span_m1_i,
   input  logic              nop_i,
   output logic [ADDR_W-1:0] idx_q,
   output logic [CNT_W-1:0]  rem_q,
   output logic              nop_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         rem_q <= '0;
         nop_q <= 1'b0;
      end else if (load_i) begin
         idx_q <= base_i;
         rem_q <= span_m1_i;
         nop_q <= nop_i;
      end else if (advance_i) begin
         idx_q <= idx_q + ADDR_W'(1);
         rem_q <= rem_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/frag_sched_ctrl.sv
module frag_sched_ctrl
   import frag_sched_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rem_zero_i,
   output logic ready_o,
   output logic load_o,
   output logic advance_o,
   output logic running_o,
   output logic last_o
);

   phase_t phase_q;

   assign running_o = (phase_q == PH_RUN);
   assign last_o    = running_o & rem_zero_i;
   assign ready_o   = ~running_o | last_o;
   assign load_o    = start_i & ready_o;
   assign advance_o = running_o & ~last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (load_o) begin
         phase_q <= PH_RUN;
      end else if (last_o) begin
         phase_q <= PH_IDLE;
      end
   end

   // a running batch must eventually count down: never run while reporting not-last forever is
   // guarded at top level; here check leaving the run phase only happens through the last cycle
   assert_leave_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && !last_o) |=> running_o);

endmodule

// File: rtl/frag_batch_sched.sv
module frag_batch_sched #(
   parameter int ADDR_W   = 6,
   parameter int CNT_W    = 2,
   parameter bit GATE_IDX = 1'b1,
   localparam int SCHED_W = ADDR_W + CNT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [SCHED_W-1:0] sched_i,
   output logic               ready_o,
   output logic [ADDR_W-1:0]  idx_o,
   output logic               idx_vld_o,
   output logic               nop_o,
   output logic               done_o
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16)
         else $error("frag_batch_sched: ADDR_W out of range");
      assert (CNT_W >= 1 && CNT_W <= 4)
         else $error("frag_batch_sched: CNT_W out of range");
   end

   logic [ADDR_W-1:0] base;
   logic [CNT_W-1:0]  span_m1;
   logic              is_nop;
   logic [ADDR_W-1:0] idx_q;
   logic [CNT_W-1:0]  rem_q;
   logic              nop_q;
   logic              load;
   logic              advance;
   logic              running;
   logic              last;

   frag_sched_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
      .word_i    (sched_i),
      .base_o    (base),
      .span_m1_o (span_m1),
      .is_nop_o  (is_nop)
   );

   frag_sched_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .rem_zero_i (rem_q == '0),
      .ready_o    (ready_o),
      .load_o     (load),
      .advance_o  (advance),
      .running_o  (running),
      .last_o     (last)
   );

   frag_sched_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .advance_i (advance),
      .base_i    (base),
      .span_m1_i (span_m1),
      .nop_i     (is_nop),
      .idx_q     (idx_q),
      .rem_q     (rem_q),
      .nop_q     (nop_q)
   );

   assign idx_vld_o = running & ~nop_q;
   assign nop_o     = running & nop_q;
   assign done_o    = last;

   generate
      if (GATE_IDX) begin : g_gate
         assign idx_o = idx_vld_o ? idx_q : '0;

         assert_idx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !idx_vld_o |-> (idx_o == '0));
      end else begin : g_raw
         assign idx_o = idx_q;
      end
   endgenerate

   // R3: first index equals the accepted offset
   assert_first_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ready_o && sched_i[CNT_W-1:0] != '0)
      |=> (idx_vld_o && idx_o == $past(sched_i[SCHED_W-1:CNT_W])));

   // R4 and R10: consecutive indices, modulo the address space
   assert_seq_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_vld_o && !done_o) |=> (idx_vld_o && idx_o == ADDR_W'($past(idx_o) + 1'b1)));

   assert_nop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nop_o |-> (done_o && !idx_vld_o));

   assert_nop_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ready_o && sched_i[CNT_W-1:0] == '0) |=> nop_o);

   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((idx_vld_o || nop_o) && !done_o) |-> !ready_o);

   assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !(start_i && ready_o)) |=> (!idx_vld_o && !nop_o));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && !done_o |-> (!idx_vld_o && !nop_o));

endmodule

// File: tb/frag_batch_sched_bench.sv
`timescale 1ns/1ps
module frag_batch_sched_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] sched = '0;
   logic       ready_o, idx_vld_o, nop_o, done_o;
   logic [5:0] idx_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   frag_batch_sched u_frag_batch_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .sched_i   (sched),
      .ready_o   (ready_o),
      .idx_o     (idx_o),
      .idx_vld_o (idx_vld_o),
      .nop_o     (nop_o),
      .done_o    (done_o)
   );

   function automatic logic [9:0] pack(bit rdy, bit vld, bit nop, bit dn, int idx);
      return {rdy, vld, nop, dn, 6'(idx)};
   endfunction

   task automatic check(input string tag, input logic [9:0] exp);
      logic [9:0] act;
      act = {ready_o, idx_vld_o, nop_o, done_o, idx_o};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: rdy/vld/nop/done/idx got %b/%b/%b/%b/%0d expected %b/%b/%b/%b/%0d",
                  tag, act[9], act[8], act[7], act[6], act[5:0],
                  exp[9], exp[8], exp[7], exp[6], exp[5:0]);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // walk one accepted batch; caller has the accepting edge just behind it
   task automatic walk(input int w, input string grp, input bit chain, input int next_w);
      int a, c, n;
      a = w >> 2;
      c = w & 3;
      n = (c == 0) ? 1 : c;
      for (int k = 0; k < n; k++) begin
         bit    last;
         string tag;
         last = (k == n - 1);
         if (c == 0)                 tag = "R6 zero count";
         else if (a + k > 63)        tag = "R10 wrap";
         else if (k == 0)            tag = "R3 first index";
         else if (last)              tag = "R5 done on last";
         else                        tag = "R4 R2 consecutive";
         check($sformatf("%s %s word=%0h k=%0d", grp, tag, w, k),
               pack(last, c != 0, c == 0, last, (c == 0) ? 0 : (a + k) % 64));
         if (chain) begin
            // R8: next word waits on start; accepted only in the final cycle
            start = (next_w >= 0);
            sched = 8'(next_w);
         end else begin
            // R7: a request during a non-final cycle must be ignored
            start = !last;
            sched = ~8'(w);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", pack(1, 0, 0, 0, 0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", pack(1, 0, 0, 0, 0));

      for (int w = 0; w < 256; w++) begin
         sched = 8'(w);
         start = 1'b1;
         @(negedge clk);
         walk(w, "sweep", 1'b0, -1);
         check($sformatf("R7 R9 idle after word=%0h", w), pack(1, 0, 0, 0, 0));
      end

      begin
         int chainw [6] = '{8'h1B, 8'h00, 8'hFE, 8'h05, 8'h00, 8'hFF};
         sched = 8'(chainw[0]);
         start = 1'b1;
         @(negedge clk);
         for (int j = 0; j < 6; j++) begin
            walk(chainw[j], "R8 chain", 1'b1, (j < 5) ? chainw[j + 1] : -1);
         end
         check("R8 idle after chain", pack(1, 0, 0, 0, 0));
      end

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang expected completion");
         summary();
         $finish;
      end
   end

endmodule